// File: doc/BRIEF.md
# Stacked-Carrier Multilevel PWM Modulator

This block turns one signed reference sample into switching commands for a single phase of an odd-level multilevel inverter. For a converter with `LEVELS` output levels it builds `LEVELS-1` triangular carriers. All carriers have the same period and the same height, and they are placed one above another so that, together, they cover the reference range symmetrically about zero. Each carrier is compared against the same reference. A switch command is asserted while the reference is strictly greater than that carrier. The block also reports the output level, which is the number of asserted commands.

All carriers come from one shared up/down counter, so they are always in phase. The input `carrier_peak` (P) sets both the height of each carrier band and the carrier period. The reference is given in the same units. The stack spans from -H to +H, where H = (LEVELS-1)*P/2. A reference outside this span is limited to it, so overmodulation holds the output at the lowest or highest level. Sine generation, dead time and the mapping of commands to particular transistors belong to neighbouring blocks.

Top module: `lspwm_modulator`

## Requirements
- R1: While reset is asserted and on the first clock after it, `sw_on` is all zeros and `level` is 0.
- R2: A clock edge that samples `en` low drives `sw_on` to zero and `level` to 0. It also restarts the shared triangle at 0, counting upward.
- R3: The shared triangle value t follows the sequence 0,1,...,P-1,P-1,...,1,0 and repeats, giving a period of 2P clocks. The first enabled edge uses t=0. If P is 0, the block treats it as 1.
- R4: Carrier k, for k from 0 to LEVELS-2, has the value k*P - H + t. Bit k of `sw_on` is 1 only when the limited reference is strictly greater than carrier k. A reference equal to a carrier does not assert that carrier's command.
- R5: `level` equals the number of set bits in `sw_on`. The set bits always run contiguously upward from bit 0, with no gaps.
- R6: A reference at or above +H gives `level` = LEVELS-1 on every cycle. A reference at or below -H gives `level` = 0 on every cycle.
- R7: A reference of exactly 0 gives `level` = (LEVELS-1)/2 on every cycle of the carrier.
- R8: Outputs are registered. The value seen after edge n reflects `ref_in`, `carrier_peak` and t as sampled at edge n.
- R9: While the reference and P stay constant, `level` changes by at most one step between consecutive enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulation enable; when low, all commands are off and the triangle restarts |
| ref_in | input | REF_W | Signed reference sample, in carrier units |
| carrier_peak | input | CNT_W | P: height of each carrier band, and half the carrier period in clocks |
| sw_on | output | LEVELS-1 | Switch commands; bit k asserted means the reference is above carrier k |
| level | output | $clog2(LEVELS) | Output level index, from 0 to LEVELS-1 |

## Verification
Two functions can act in the same cycle: the triangle pausing at one of its turning points, and the strict comparison against a carrier. When the reference exactly equals a carrier's value during the pause, that carrier's command must stay off for both cycles of the pause. The bench provokes this with P=4 and a reference of -4. That reference coincides with carrier 1 at its lowest point, so the level must stay at 1 through the turnaround rather than flicker to 2. A second case pairs a carrier crossing with the upper turning point (P=2, reference 1). Here the bench checks that the level reaches 2 and then holds for exactly two cycles before returning to 3.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;
   // Width needed to hold the reference, the carrier stack, and signed margin.
   function automatic int calc_val_w(int ref_w, int cnt_w, int levels);
      int stack_w;
      stack_w = cnt_w + $clog2(levels) + 1;
      return ((ref_w > stack_w) ? ref_w : stack_w) + 2;
   endfunction
endpackage

// File: rtl/lspwm_tri_counter.sv
module lspwm_tri_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] peak_eff,
   output logic [CNT_W-1:0] tri_val
);
   logic             going_up;
   logic [CNT_W-1:0] top_val;

   assign top_val = peak_eff - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tri_val  <= '0;
         going_up <= 1'b1;
      end else if (!en) begin
         tri_val  <= '0;
         going_up <= 1'b1;
      end else if (going_up) begin
         if (tri_val >= top_val) going_up <= 1'b0;       // pause one clock at the top
         else                    tri_val  <= tri_val + CNT_W'(1);
      end else begin
         if (tri_val == '0) going_up <= 1'b1;            // pause one clock at the bottom
         else               tri_val  <= tri_val - CNT_W'(1);
      end
   end
endmodule

// File: rtl/lspwm_ref_limit.sv
module lspwm_ref_limit #(
   parameter int REF_W  = 16,
   parameter int VAL_W  = 18,
   parameter int LEVELS = 5
) (
   input  logic signed [REF_W-1:0] ref_in,
   input  logic signed [VAL_W-1:0] peak_v,
   output logic signed [VAL_W-1:0] half_span,
   output logic signed [VAL_W-1:0] ref_sat
);
   localparam int HALF_CAR = (LEVELS - 1) / 2;
   localparam logic signed [VAL_W-1:0] HALF_CAR_V = VAL_W'(HALF_CAR);

   logic signed [VAL_W-1:0] ref_ext;

   assign ref_ext   = VAL_W'(ref_in);
   assign half_span = HALF_CAR_V * peak_v;

   always_comb begin
      if (ref_ext > half_span)       ref_sat = half_span;
      else if (ref_ext < -half_span) ref_sat = -half_span;
      else                           ref_sat = ref_ext;
   end
endmodule

// File: rtl/lspwm_band_cmp.sv
module lspwm_band_cmp #(
   parameter int VAL_W = 18,
   parameter int NCAR  = 4
) (
   input  logic signed [VAL_W-1:0] ref_sat,
   input  logic signed [VAL_W-1:0] peak_v,
   input  logic signed [VAL_W-1:0] half_span,
   input  logic signed [VAL_W-1:0] tri_v,
   output logic        [NCAR-1:0]  hit
);
   logic signed [VAL_W-1:0] base;

   assign base = tri_v - half_span;

   for (genvar k = 0; k < NCAR; k++) begin : g_band
      localparam logic signed [VAL_W-1:0] K_V = VAL_W'(k);
      logic signed [VAL_W-1:0] carrier;
      assign carrier = K_V * peak_v + base;
      assign hit[k]  = ref_sat > carrier;
   end
endmodule

// File: rtl/lspwm_modulator.sv
module lspwm_modulator #(
   parameter int LEVELS = 5,
   parameter int REF_W  = 16,
   parameter int CNT_W  = 10,
   localparam int NCAR  = LEVELS - 1,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic        [CNT_W-1:0] carrier_peak,
   output logic        [NCAR-1:0]  sw_on,
   output logic        [LVL_W-1:0] level
);
   localparam int VAL_W = lspwm_pkg::calc_val_w(REF_W, CNT_W, LEVELS);

   if (LEVELS < 3 || (LEVELS % 2) == 0) begin : g_bad_levels
      $error("lspwm_modulator: LEVELS must be odd and at least 3");
   end
   if (REF_W < 2 || CNT_W < 1) begin : g_bad_widths
      $error("lspwm_modulator: REF_W >= 2 and CNT_W >= 1 required");
   end

   logic        [CNT_W-1:0] peak_eff;
   logic        [CNT_W-1:0] tri_val;
   logic signed [VAL_W-1:0] peak_v, tri_v, half_span, ref_sat;
   logic        [NCAR-1:0]  hit;
   logic        [LVL_W-1:0] level_c;

   assign peak_eff = (carrier_peak == '0) ? CNT_W'(1) : carrier_peak;
   assign peak_v   = VAL_W'(peak_eff);
   assign tri_v    = VAL_W'(tri_val);

   lspwm_tri_counter #(.CNT_W(CNT_W)) u_tri (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .peak_eff (peak_eff),
      .tri_val  (tri_val)
   );

   lspwm_ref_limit #(.REF_W(REF_W), .VAL_W(VAL_W), .LEVELS(LEVELS)) u_lim (
      .ref_in    (ref_in),
      .peak_v    (peak_v),
      .half_span (half_span),
      .ref_sat   (ref_sat)
   );

   lspwm_band_cmp #(.VAL_W(VAL_W), .NCAR(NCAR)) u_cmp (
      .ref_sat   (ref_sat),
      .peak_v    (peak_v),
      .half_span (half_span),
      .tri_v     (tri_v),
      .hit       (hit)
   );

   always_comb begin
      level_c = '0;
      for (int k = 0; k < NCAR; k++) level_c = level_c + LVL_W'(hit[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_on <= '0;
         level <= '0;
      end else if (!en) begin
         sw_on <= '0;
         level <= '0;
      end else begin
         sw_on <= hit;
         level <= level_c;
      end
   end
endmodule

// File: rtl/lspwm_modulator_chk.sv
module lspwm_modulator_chk #(
   parameter int LEVELS = 5,
   parameter int REF_W  = 16,
   parameter int CNT_W  = 10,
   localparam int NCAR  = LEVELS - 1,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    en,
   input logic signed [REF_W-1:0] ref_in,
   input logic        [CNT_W-1:0] carrier_peak,
   input logic        [NCAR-1:0]  sw_on,
   input logic        [LVL_W-1:0] level
);
   // R2
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (sw_on == '0 && level == '0));

   // R5
   level_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) == $countones(sw_on));

   // R5
   thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_on & (sw_on + NCAR'(1))) == '0));

   // R9
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(en, 2) && $past(ref_in) == $past(ref_in, 2) &&
       $past(carrier_peak) == $past(carrier_peak, 2))
      |-> ((int'(level) - int'($past(level)) <= 1) &&
           (int'($past(level)) - int'(level) <= 1)));
endmodule

bind lspwm_modulator lspwm_modulator_chk #(
   .LEVELS (LEVELS),
   .REF_W  (REF_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .ref_in       (ref_in),
   .carrier_peak (carrier_peak),
   .sw_on        (sw_on),
   .level        (level)
);

// File: tb/lspwm_modulator_tb.sv
module lspwm_modulator_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LEVELS = 5;
   localparam int REF_W  = 16;
   localparam int CNT_W  = 10;
   localparam int NCAR   = LEVELS - 1;
   localparam int LVL_W  = $clog2(LEVELS);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    en = 1'b0;
   logic signed [REF_W-1:0] ref_in = '0;
   logic        [CNT_W-1:0] carrier_peak = CNT_W'(4);
   logic        [NCAR-1:0]  sw_on;
   logic        [LVL_W-1:0] level;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lspwm_modulator #(.LEVELS(LEVELS), .REF_W(REF_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in),
      .carrier_peak(carrier_peak), .sw_on(sw_on), .level(level)
   );

   task automatic check(string req, int actual, int expected);
      n_checks++;
      if (actual != expected) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   // Triangle value at enabled edge n (R3).
   function automatic int tri_at(int n, int p);
      int r;
      r = n % (2 * p);
      return (r < p) ? r : (2 * p - 1 - r);
   endfunction

   // Expected command mask from the stacked-carrier rule (R4, R6).
   function automatic int exp_mask(int refv, int p_raw, int t);
      int p, h, r, m;
      p = (p_raw == 0) ? 1 : p_raw;
      h = (LEVELS - 1) * p / 2;
      r = (refv > h) ? h : ((refv < -h) ? -h : refv);
      m = 0;
      for (int k = 0; k < NCAR; k++)
         if (r > k * p - h + t) m = m | (1 << k);
      return m;
   endfunction

   // Disable for one edge, then run ncyc enabled edges with fixed inputs.
   task automatic run_phase(string req, int refv, int p, int ncyc);
      @(negedge clk);
      en = 1'b0;
      ref_in = REF_W'(refv);
      carrier_peak = CNT_W'(p);
      @(negedge clk);
      check("R2 disabled mask", int'(sw_on), 0);
      en = 1'b1;
      for (int n = 0; n < ncyc; n++) begin
         int m, t;
         @(negedge clk);
         t = tri_at(n, (p == 0) ? 1 : p);
         m = exp_mask(refv, p, t);
         check({req, " mask"}, int'(sw_on), m);
         check({req, " level"}, int'(level), $countones(m));
      end
   endtask

   task automatic test_reset();
      check("R1 reset mask", int'(sw_on), 0);
      check("R1 reset level", int'(level), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first clock mask", int'(sw_on), 0);
      check("R1 first clock level", int'(level), 0);
   endtask

   task automatic test_triangle();
      // R3 R8: P=4, ref=1 -> level 3 only when t=0.
      run_phase("R3 triangle P4", 1, 4, 18);
      // R3: P=2, ref=1 -> level 3,2,2,3,3,2...
      run_phase("R3 triangle P2", 1, 2, 10);
   endtask

   task automatic test_strict_equal();
      // R4: ref=-4 equals carrier 1 at its bottom pause; level stays 1.
      run_phase("R4 equal carrier", -4, 4, 12);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R4 equal level held", int'(level), 1);
      end
   endtask

   task automatic test_saturation();
      run_phase("R6 top clamp", 32767, 4, 10);
      check("R6 top level", int'(level), LEVELS - 1);
      run_phase("R6 bottom clamp", -32768, 4, 10);
      check("R6 bottom level", int'(level), 0);
      run_phase("R6 just above span", 9, 4, 8);
   endtask

   task automatic test_zero();
      run_phase("R7 zero ref", 0, 4, 10);
      check("R7 zero level", int'(level), (LEVELS - 1) / 2);
      run_phase("R7 zero ref P7", 0, 7, 16);
   endtask

   task automatic test_peak_zero();
      run_phase("R3 peak zero", 0, 0, 6);
      run_phase("R3 peak zero neg", -1, 0, 6);
   endtask

   task automatic test_disable_mid();
      run_phase("R5 mid level", 3, 4, 5);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R2 dropped mask", int'(sw_on), 0);
      check("R2 dropped level", int'(level), 0);
   endtask

   initial begin
      test_reset();
      test_triangle();
      test_strict_equal();
      test_saturation();
      test_zero();
      test_peak_zero();
      test_disable_mid();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule